// File: doc/BRIEF.md
# Indexed Display Mode Register Port

This block is the control-register front end of a display adapter. Software reaches a few dozen 32-bit registers through only two data ports. It first writes a register number to the index port, then reads or writes that register through the value port. A third port is a placeholder that always returns a fixed word.

Behind the ports sits the mode state: enable, pending width and height, and a fixed colour depth. Several values are computed from that state: bits per pixel, bytes per line and the frame size. The block also holds the colour masks, a capability word, cursor state, a sync/busy handshake and a bank of scratch words. The drawing side receives the configured flag, a one-cycle sync request, the mode values and a dirty flag, and acknowledges a mode change with `mode_ack_i`.

Top module: `cfg_regport`

## Requirements
- R1: A write on port 0 stores the index, and a read on port 0 returns it. Port 2 reads 0x0000CAFE and ignores writes, and port 3 reads 0. The value port is port 1.
- R2: Register 0 (identity) resets to 0x90000002. A write to it is accepted only for 0x90000000, 0x90000001 or 0x90000002; any other value is ignored.
- R3: A write to register 1 stores the enable value and sets `mode_dirty_o`, and a zero value clears `configured_o`. A non-zero value latches the frame size (register 16) as ((DEPTH+7)>>3) × width × height. `mode_ack_i` clears `mode_dirty_o`.
- R4: Registers 7 and 28 read (DEPTH+7) with the low three bits cleared. Register 12 reads ((DEPTH+7)>>3) × the pending width (register 2).
- R5: Registers 4 and 5 read the maximum width and height parameters, 2360 and 1770 by default.
- R6: A write to register 6 or 7 with a value other than DEPTH clears `configured_o`. A matching value leaves it unchanged.
- R7: Register 17 reads bits 0 and 1 set, plus bits 5, 6 and 7 when CURSOR_EN is 1.
- R8: A write of 1 to register 27 sets `cursor_on_o`, and a write of 0 clears it. Writes of 2 or 3 leave it unchanged.
- R9: Indices 1024 to 1791 read 0 and ignore writes. Indices 1792 to 1792+SCRATCH_WORDS-1 read and write scratch words.
- R10: A write to register 21 sets `busy_o` and pulses `sync_req_o` for one cycle. Registers 21 and 22 both read the busy flag, and `drain_done_i` clears it.
- R11: Registers 9, 10 and 11 read the red, green and blue masks for DEPTH. For depth 16 these are 0x1F, 0x7E0 and 0xF800; for depth 15 they are 0x1F, 0x3E0 and 0x7C00; for depths 24 and 32 they are 0xFF0000, 0xFF00 and 0xFF.
- R12: A value-port read or write at any other index returns 0 and sets `err_o`. The flag stays set until reset.
- R13: A write to register 20 sets `configured_o` when the value is non-zero and clears it when the value is zero. Register 20 reads the flag back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_port_i | input | 2 | Port select (0 index, 1 value, 2 placeholder) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected port (combinational) |
| drain_done_i | input | 1 | Drawing side has finished a drain; clears busy |
| mode_ack_i | input | 1 | Drawing side has applied the mode; clears dirty |
| configured_o | output | 1 | Configuration complete flag |
| busy_o | output | 1 | Sync in progress |
| sync_req_o | output | 1 | One-cycle drain request |
| enable_o | output | 1 | Enable register is non-zero |
| width_o | output | 32 | Pending width |
| height_o | output | 32 | Pending height |
| fb_size_o | output | 32 | Frame size latched at enable |
| mode_dirty_o | output | 1 | Mode changed since last acknowledge |
| cursor_on_o | output | 1 | Cursor visible |
| cursor_x_o | output | 32 | Cursor X |
| cursor_y_o | output | 32 | Cursor Y |
| err_o | output | 1 | Sticky unknown-index flag |

## Verification
The bench builds the block with DEPTH=16, SCRATCH_WORDS=8 and CURSOR_EN=1. Depth 16 makes the byte-per-pixel factor 2, so bytes per line and frame size are real products and not plain copies of width. It also gives masks that differ from the 24-bit defaults. Eight scratch words put the last valid word at index 1799, so the bench reaches both the upper scratch edge and the first index past it, 1800. With the cursor enabled, all five capability bits show.

// File: rtl/cfg_regport_pkg.sv
package cfg_regport_pkg;
  localparam logic [31:0] IX_ID      = 32'd0;
  localparam logic [31:0] IX_EN      = 32'd1;
  localparam logic [31:0] IX_WIDTH   = 32'd2;
  localparam logic [31:0] IX_HEIGHT  = 32'd3;
  localparam logic [31:0] IX_MAXW    = 32'd4;
  localparam logic [31:0] IX_MAXH    = 32'd5;
  localparam logic [31:0] IX_DEPTH   = 32'd6;
  localparam logic [31:0] IX_BPP     = 32'd7;
  localparam logic [31:0] IX_PSEUDO  = 32'd8;
  localparam logic [31:0] IX_RMASK   = 32'd9;
  localparam logic [31:0] IX_GMASK   = 32'd10;
  localparam logic [31:0] IX_BMASK   = 32'd11;
  localparam logic [31:0] IX_BPL     = 32'd12;
  localparam logic [31:0] IX_FBSTART = 32'd13;
  localparam logic [31:0] IX_FBOFS   = 32'd14;
  localparam logic [31:0] IX_VRAM    = 32'd15;
  localparam logic [31:0] IX_FBSIZE  = 32'd16;
  localparam logic [31:0] IX_CAPS    = 32'd17;
  localparam logic [31:0] IX_RINGST  = 32'd18;
  localparam logic [31:0] IX_RINGSZ  = 32'd19;
  localparam logic [31:0] IX_CFGDONE = 32'd20;
  localparam logic [31:0] IX_SYNC    = 32'd21;
  localparam logic [31:0] IX_BUSY    = 32'd22;
  localparam logic [31:0] IX_GUEST   = 32'd23;
  localparam logic [31:0] IX_CURID   = 32'd24;
  localparam logic [31:0] IX_CURX    = 32'd25;
  localparam logic [31:0] IX_CURY    = 32'd26;
  localparam logic [31:0] IX_CURON   = 32'd27;
  localparam logic [31:0] IX_HOSTBPP = 32'd28;
  localparam logic [31:0] IX_SCRSZ   = 32'd29;
  localparam logic [31:0] IX_LAST    = 32'd32;
  localparam logic [31:0] PAL_LO     = 32'd1024;
  localparam logic [31:0] PAL_HI     = 32'd1791;
  localparam logic [31:0] SCR_BASE   = 32'd1792;

  localparam logic [31:0] ID_V0 = 32'h9000_0000;
  localparam logic [31:0] ID_V1 = 32'h9000_0001;
  localparam logic [31:0] ID_V2 = 32'h9000_0002;
  localparam logic [31:0] STUB_WORD = 32'h0000_CAFE;

  // {red, green, blue}
  function automatic logic [95:0] depth_masks(input int unsigned depth);
    case (depth)
      8:       return {32'h07, 32'h38, 32'hC0};
      15:      return {32'h1F, 32'h3E0, 32'h7C00};
      16:      return {32'h1F, 32'h7E0, 32'hF800};
      default: return {32'hFF_0000, 32'hFF00, 32'hFF};
    endcase
  endfunction
endpackage

// File: rtl/cfg_mode_calc.sv
module cfg_mode_calc #(
  parameter int unsigned DEPTH = 24
) (
  input  logic [31:0] pend_w_i,
  input  logic [31:0] pend_h_i,
  output logic [31:0] bpp_o,
  output logic [31:0] bpl_o,
  output logic [31:0] fb_bytes_o
);
  localparam int unsigned BYTES_PP = (DEPTH + 7) >> 3;
  localparam int unsigned BPP      = BYTES_PP * 8;

  assign bpp_o      = 32'(BPP);
  assign bpl_o      = pend_w_i * 32'(BYTES_PP);
  assign fb_bytes_o = bpl_o * pend_h_i;
endmodule

// File: rtl/cfg_scratch_bank.sv
module cfg_scratch_bank #(
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/cfg_regport.sv
module cfg_regport
  import cfg_regport_pkg::*;
#(
  parameter int unsigned DEPTH         = 24,
  parameter int unsigned SCRATCH_WORDS = 64,
  parameter bit          CURSOR_EN     = 1'b1,
  parameter logic [31:0] MAX_W         = 32'd2360,
  parameter logic [31:0] MAX_H         = 32'd1770,
  parameter logic [31:0] FB_BASE       = 32'hE000_0000,
  parameter logic [31:0] VRAM_BYTES    = 32'h0100_0000,
  parameter logic [31:0] RING_BYTES    = 32'h0001_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [1:0]  bus_port_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        drain_done_i,
  input  logic        mode_ack_i,
  output logic        configured_o,
  output logic        busy_o,
  output logic        sync_req_o,
  output logic        enable_o,
  output logic [31:0] width_o,
  output logic [31:0] height_o,
  output logic [31:0] fb_size_o,
  output logic        mode_dirty_o,
  output logic        cursor_on_o,
  output logic [31:0] cursor_x_o,
  output logic [31:0] cursor_y_o,
  output logic        err_o
);
  localparam int unsigned AW = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;
  localparam logic [95:0] MASKS = depth_masks(DEPTH);
  localparam logic [31:0] CAPS  = CURSOR_EN ? 32'h0000_00E3 : 32'h0000_0003;

  logic [31:0] idx_q, id_q, en_q, pw_q, ph_q, fb_q, guest_q, cid_q, cx_q, cy_q;
  logic        cfg_q, busy_q, sync_q, dirty_q, con_q, err_q;
  logic [31:0] bpp, bpl, fb_calc, scr_off, scr_rdata, val_rdata;
  logic        val_wr, val_acc, scr_hit, pal_hit, known;

  assign val_wr  = bus_wr_i && (bus_port_i == 2'd1);
  assign val_acc = (bus_wr_i || bus_rd_i) && (bus_port_i == 2'd1);
  assign scr_off = idx_q - SCR_BASE;
  assign scr_hit = (idx_q >= SCR_BASE) && (scr_off < 32'(SCRATCH_WORDS));
  assign pal_hit = (idx_q >= PAL_LO) && (idx_q <= PAL_HI);
  assign known   = (idx_q <= IX_LAST) || pal_hit || scr_hit;

  cfg_mode_calc #(.DEPTH(DEPTH)) i_calc (
    .pend_w_i  (pw_q),
    .pend_h_i  (ph_q),
    .bpp_o     (bpp),
    .bpl_o     (bpl),
    .fb_bytes_o(fb_calc)
  );

  cfg_scratch_bank #(.WORDS(SCRATCH_WORDS)) i_scratch (
    .clk_i  (clk_i),
    .we_i   (val_wr && scr_hit),
    .addr_i (scr_off[AW-1:0]),
    .wdata_i(bus_wdata_i),
    .rdata_o(scr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0; id_q <= ID_V2; en_q <= '0; pw_q <= '0; ph_q <= '0;
      fb_q <= '0; guest_q <= '0; cid_q <= '0; cx_q <= '0; cy_q <= '0;
      cfg_q <= 1'b0; busy_q <= 1'b0; sync_q <= 1'b0; dirty_q <= 1'b0;
      con_q <= 1'b0; err_q <= 1'b0;
    end else begin
      sync_q <= 1'b0;
      if (drain_done_i) busy_q  <= 1'b0;
      if (mode_ack_i)   dirty_q <= 1'b0;
      if (bus_wr_i && bus_port_i == 2'd0) idx_q <= bus_wdata_i;
      if (val_acc && !known) err_q <= 1'b1;
      if (val_wr) begin
        case (idx_q)
          IX_ID:
            if (bus_wdata_i == ID_V0 || bus_wdata_i == ID_V1 || bus_wdata_i == ID_V2)
              id_q <= bus_wdata_i;
          IX_EN: begin
            en_q    <= bus_wdata_i;
            dirty_q <= 1'b1;
            if (bus_wdata_i == '0) cfg_q <= 1'b0;
            else                   fb_q  <= fb_calc;
          end
          IX_WIDTH:  begin pw_q <= bus_wdata_i; dirty_q <= 1'b1; end
          IX_HEIGHT: begin ph_q <= bus_wdata_i; dirty_q <= 1'b1; end
          IX_DEPTH, IX_BPP:
            if (bus_wdata_i != 32'(DEPTH)) cfg_q <= 1'b0;
          IX_CFGDONE: cfg_q <= |bus_wdata_i;
          IX_SYNC: begin busy_q <= 1'b1; sync_q <= 1'b1; end
          IX_GUEST: guest_q <= bus_wdata_i;
          IX_CURID: cid_q   <= bus_wdata_i;
          IX_CURX:  cx_q    <= bus_wdata_i;
          IX_CURY:  cy_q    <= bus_wdata_i;
          IX_CURON: con_q   <= (con_q | (bus_wdata_i == 32'd1)) & (bus_wdata_i != 32'd0);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx_q)
      IX_ID:               val_rdata = id_q;
      IX_EN:               val_rdata = en_q;
      IX_WIDTH:            val_rdata = pw_q;
      IX_HEIGHT:           val_rdata = ph_q;
      IX_MAXW:             val_rdata = MAX_W;
      IX_MAXH:             val_rdata = MAX_H;
      IX_DEPTH:            val_rdata = 32'(DEPTH);
      IX_BPP, IX_HOSTBPP:  val_rdata = bpp;
      IX_RMASK:            val_rdata = MASKS[95:64];
      IX_GMASK:            val_rdata = MASKS[63:32];
      IX_BMASK:            val_rdata = MASKS[31:0];
      IX_BPL:              val_rdata = bpl;
      IX_FBSTART:          val_rdata = FB_BASE;
      IX_VRAM:             val_rdata = VRAM_BYTES - RING_BYTES;
      IX_FBSIZE:           val_rdata = fb_q;
      IX_CAPS:             val_rdata = CAPS;
      IX_RINGST:           val_rdata = FB_BASE + VRAM_BYTES - RING_BYTES;
      IX_RINGSZ:           val_rdata = RING_BYTES;
      IX_CFGDONE:          val_rdata = {31'd0, cfg_q};
      IX_SYNC, IX_BUSY:    val_rdata = {31'd0, busy_q};
      IX_GUEST:            val_rdata = guest_q;
      IX_CURID:            val_rdata = cid_q;
      IX_CURX:             val_rdata = cx_q;
      IX_CURY:             val_rdata = cy_q;
      IX_CURON:            val_rdata = {31'd0, con_q};
      IX_SCRSZ:            val_rdata = 32'(SCRATCH_WORDS);
      default:             val_rdata = scr_hit ? scr_rdata : 32'd0;
    endcase
  end

  always_comb begin
    case (bus_port_i)
      2'd0:    bus_rdata_o = idx_q;
      2'd1:    bus_rdata_o = val_rdata;
      2'd2:    bus_rdata_o = STUB_WORD;
      default: bus_rdata_o = 32'd0;
    endcase
  end

  assign configured_o = cfg_q;
  assign busy_o       = busy_q;
  assign sync_req_o   = sync_q;
  assign enable_o     = |en_q;
  assign width_o      = pw_q;
  assign height_o     = ph_q;
  assign fb_size_o    = fb_q;
  assign mode_dirty_o = dirty_q;
  assign cursor_on_o  = con_q;
  assign cursor_x_o   = cx_q;
  assign cursor_y_o   = cy_q;
  assign err_o        = err_q;
endmodule

// File: rtl/cfg_regport_chk.sv
module cfg_regport_chk #(
  parameter int unsigned DEPTH = 24
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        val_wr_i,
  input logic [31:0] idx_i,
  input logic [31:0] wdata_i,
  input logic [31:0] id_i,
  input logic        configured_i,
  input logic        sync_req_i,
  input logic        busy_i,
  input logic        cursor_on_i,
  input logic        err_i
);
  AST_ID_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_i == 32'h9000_0000) || (id_i == 32'h9000_0001) || (id_i == 32'h9000_0002)); // R2

  AST_EN_ZERO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_wr_i && idx_i == 32'd1 && wdata_i == 32'd0) |=> !configured_i); // R3

  AST_DEPTH_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_wr_i && (idx_i == 32'd6 || idx_i == 32'd7) && wdata_i != 32'(DEPTH))
      |=> !configured_i); // R6

  AST_CURSOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_wr_i && idx_i == 32'd27 && (wdata_i == 32'd2 || wdata_i == 32'd3))
      |=> $stable(cursor_on_i)); // R8

  AST_SYNC_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_req_i |-> busy_i); // R10

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i); // R12
endmodule

bind cfg_regport cfg_regport_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .val_wr_i    (val_wr),
  .idx_i       (idx_q),
  .wdata_i     (bus_wdata_i),
  .id_i        (id_q),
  .configured_i(configured_o),
  .sync_req_i  (sync_req_o),
  .busy_i      (busy_o),
  .cursor_on_i (cursor_on_o),
  .err_i       (err_o)
);

// File: tb/test_cfg_regport.sv
module test_cfg_regport;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, drain_done = 1'b0, mode_ack = 1'b0;
  logic [1:0]  bus_port = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        configured, busy, sync_req, enable, mode_dirty, cursor_on, err;
  logic [31:0] width, height, fb_size, cur_x, cur_y;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cfg_regport #(.DEPTH(16), .SCRATCH_WORDS(8), .CURSOR_EN(1'b1)) i_cfg_regport (
    .clk_i(clk), .rst_ni(rst_ni), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_port_i(bus_port), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .drain_done_i(drain_done), .mode_ack_i(mode_ack), .configured_o(configured),
    .busy_o(busy), .sync_req_o(sync_req), .enable_o(enable), .width_o(width),
    .height_o(height), .fb_size_o(fb_size), .mode_dirty_o(mode_dirty),
    .cursor_on_o(cursor_on), .cursor_x_o(cur_x), .cursor_y_o(cur_y), .err_o(err)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  port;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 32'd0,          32'd0,          4'd2},
    '{1'b1, 2'd1, 32'd0,          32'h9000_0002,  4'd2},  // R2 reset id
    '{1'b0, 2'd1, 32'h1234_5678,  32'd0,          4'd2},
    '{1'b1, 2'd1, 32'd0,          32'h9000_0002,  4'd2},  // R2 illegal ignored
    '{1'b0, 2'd1, 32'h9000_0001,  32'd0,          4'd2},
    '{1'b1, 2'd1, 32'd0,          32'h9000_0001,  4'd2},  // R2 legal taken
    '{1'b0, 2'd0, 32'd4,          32'd0,          4'd5},
    '{1'b1, 2'd1, 32'd0,          32'd2360,       4'd5},  // R5
    '{1'b0, 2'd0, 32'd5,          32'd0,          4'd5},
    '{1'b1, 2'd1, 32'd0,          32'd1770,       4'd5},
    '{1'b0, 2'd0, 32'd7,          32'd0,          4'd4},
    '{1'b1, 2'd1, 32'd0,          32'd16,         4'd4},  // R4 bpp
    '{1'b0, 2'd0, 32'd28,         32'd0,          4'd4},
    '{1'b1, 2'd1, 32'd0,          32'd16,         4'd4},
    '{1'b0, 2'd0, 32'd2,          32'd0,          4'd4},
    '{1'b0, 2'd1, 32'd640,        32'd0,          4'd4},
    '{1'b0, 2'd0, 32'd3,          32'd0,          4'd4},
    '{1'b0, 2'd1, 32'd480,        32'd0,          4'd4},
    '{1'b0, 2'd0, 32'd12,         32'd0,          4'd4},
    '{1'b1, 2'd1, 32'd0,          32'd1280,       4'd4},  // R4 bytes per line
    '{1'b0, 2'd0, 32'd9,          32'd0,          4'd11},
    '{1'b1, 2'd1, 32'd0,          32'h1F,         4'd11}, // R11
    '{1'b0, 2'd0, 32'd10,         32'd0,          4'd11},
    '{1'b1, 2'd1, 32'd0,          32'h7E0,        4'd11},
    '{1'b0, 2'd0, 32'd11,         32'd0,          4'd11},
    '{1'b1, 2'd1, 32'd0,          32'hF800,       4'd11},
    '{1'b0, 2'd0, 32'd17,         32'd0,          4'd7},
    '{1'b1, 2'd1, 32'd0,          32'hE3,         4'd7},  // R7
    '{1'b0, 2'd0, 32'd1799,       32'd0,          4'd9},
    '{1'b0, 2'd1, 32'hDEAD_BEEF,  32'd0,          4'd9},
    '{1'b0, 2'd0, 32'd1792,       32'd0,          4'd9},
    '{1'b0, 2'd1, 32'h11,         32'd0,          4'd9},
    '{1'b0, 2'd0, 32'd1799,       32'd0,          4'd9},
    '{1'b1, 2'd1, 32'd0,          32'hDEAD_BEEF,  4'd9},  // R9 top scratch word
    '{1'b0, 2'd0, 32'd1792,       32'd0,          4'd9},
    '{1'b1, 2'd1, 32'd0,          32'h11,         4'd9},
    '{1'b0, 2'd0, 32'd1024,       32'd0,          4'd9},
    '{1'b0, 2'd1, 32'd5,          32'd0,          4'd9},
    '{1'b1, 2'd1, 32'd0,          32'd0,          4'd9},  // R9 palette window
    '{1'b0, 2'd0, 32'd1791,       32'd0,          4'd9},
    '{1'b1, 2'd1, 32'd0,          32'd0,          4'd9},
    '{1'b1, 2'd0, 32'd0,          32'd1791,       4'd1},  // R1 index readback
    '{1'b1, 2'd2, 32'd0,          32'h0000_CAFE,  4'd1},
    '{1'b0, 2'd2, 32'd1,          32'd0,          4'd1},
    '{1'b1, 2'd0, 32'd0,          32'd1791,       4'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [1:0] port, input logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk);
    bus_wr = wr; bus_rd = !wr; bus_port = port; bus_wdata = d;
    #1 rd = bus_rdata;
    @(posedge clk);
    #1 bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [31:0] idx, input logic [31:0] d);
    logic [31:0] unused;
    acc(1'b1, 2'd0, idx, unused);
    acc(1'b1, 2'd1, d, unused);
  endtask

  task automatic rd_reg(input logic [31:0] idx, output logic [31:0] v);
    logic [31:0] unused;
    acc(1'b1, 2'd0, idx, unused);
    acc(1'b0, 2'd1, 32'd0, v);
  endtask

  task automatic pulse(input bit sel);
    @(negedge clk);
    if (sel) drain_done = 1'b1; else mode_ack = 1'b1;
    @(posedge clk);
    #1 drain_done = 1'b0; mode_ack = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state
    chk("R13 reset configured", {31'd0, configured}, 32'd0);
    chk("R10 reset busy", {31'd0, busy}, 32'd0);
    chk("R12 reset err", {31'd0, err}, 32'd0);
    chk("R8 reset cursor", {31'd0, cursor_on}, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      acc(!VEC[i].rd, VEC[i].port, VEC[i].data, r);
      if (VEC[i].rd) chk($sformatf("R%0d vector %0d", VEC[i].req, i), r, VEC[i].exp);
    end
    chk("R12 known indices leave err clear", {31'd0, err}, 32'd0);

    // R13 config done
    wr_reg(32'd20, 32'd1);
    chk("R13 configured set", {31'd0, configured}, 32'd1);
    rd_reg(32'd20, r);
    chk("R13 readback", r, 32'd1);
    // R6 depth guard
    wr_reg(32'd6, 32'd16);
    chk("R6 matching depth keeps", {31'd0, configured}, 32'd1);
    wr_reg(32'd6, 32'd24);
    chk("R6 mismatched depth clears", {31'd0, configured}, 32'd0);
    wr_reg(32'd20, 32'd1);
    wr_reg(32'd7, 32'd8);
    chk("R6 mismatched bpp clears", {31'd0, configured}, 32'd0);
    wr_reg(32'd20, 32'd0);
    chk("R13 zero clears", {31'd0, configured}, 32'd0);

    // R3 enable
    pulse(1'b0);
    chk("R3 ack clears dirty", {31'd0, mode_dirty}, 32'd0);
    wr_reg(32'd20, 32'd1);
    wr_reg(32'd1, 32'd1);
    chk("R3 enable out", {31'd0, enable}, 32'd1);
    chk("R3 nonzero keeps configured", {31'd0, configured}, 32'd1);
    chk("R3 dirty set", {31'd0, mode_dirty}, 32'd1);
    rd_reg(32'd16, r);
    chk("R3 frame size", r, 32'd614400);
    chk("R3 frame size port", fb_size, 32'd614400);
    wr_reg(32'd1, 32'd0);
    chk("R3 zero enable drops configured", {31'd0, configured}, 32'd0);
    chk("R3 enable low", {31'd0, enable}, 32'd0);

    // R8 cursor codes
    wr_reg(32'd27, 32'd1);
    chk("R8 show", {31'd0, cursor_on}, 32'd1);
    wr_reg(32'd27, 32'd2);
    chk("R8 code 2 holds", {31'd0, cursor_on}, 32'd1);
    wr_reg(32'd27, 32'd0);
    chk("R8 hide", {31'd0, cursor_on}, 32'd0);
    wr_reg(32'd27, 32'd3);
    chk("R8 code 3 holds", {31'd0, cursor_on}, 32'd0);

    // R10 sync
    wr_reg(32'd21, 32'd1);
    chk("R10 sync pulse", {31'd0, sync_req}, 32'd1);
    chk("R10 busy set", {31'd0, busy}, 32'd1);
    @(posedge clk); #1;
    chk("R10 pulse one cycle", {31'd0, sync_req}, 32'd0);
    rd_reg(32'd22, r);
    chk("R10 busy reads 1", r, 32'd1);
    pulse(1'b1);
    rd_reg(32'd21, r);
    chk("R10 drain clears busy", r, 32'd0);

    // R12 unknown index, just past scratch
    rd_reg(32'd1800, r);
    chk("R12 unknown reads 0", r, 32'd0);
    chk("R12 err set", {31'd0, err}, 32'd1);
    rd_reg(32'd0, r);
    chk("R12 err sticky", {31'd0, err}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule